// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Assembler

This block sits between an instruction fetch path and a decoder. It accepts a stream of 16-bit instruction parcels, one per handshake, in increasing halfword address order. The first parcel of each instruction carries a layered length code in its low bits. The block reads that code, gathers the right number of parcels, and hands the decoder one instruction word. The word comes with its length in parcels and a flag for an illegal encoding.

The assembled word is `ILEN` bits wide. A parameter chooses whether 16-bit (compressed) instructions are legal. The parcel side and the instruction side each use a valid/ready handshake. A flush input throws away a half-gathered instruction, for example after a taken branch. A completed instruction that is already waiting at the output is kept. While that instruction waits, the parcel side is not ready, so no parcel is lost or reordered.

Top module: `parcel_assembler`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The length in parcels comes from the first parcel `p`, with checks applied in this order.
  - `p[1:0]` is not `11`: 1 parcel.
  - Otherwise, `p[4:2]` is not `111`: 2 parcels.
  - Otherwise, `p[5]` is 0: 3 parcels.
  - Otherwise, `p[6]` is 0: 4 parcels.
  - Otherwise, `p[14:12]` is not `111`: 5 + `p[14:12]` parcels.
- R3: The first parcel supplies `out_insn[15:0]`, and parcel k supplies `out_insn[16k+15:16k]`. Every bit above the reported length is 0.
- R4: A first parcel equal to 16'h0000 is flagged illegal. It is 1 parcel long when compressed support is on, and 2 parcels long when it is off.
- R5: With compressed support off, a first parcel whose `p[1:0]` is not `11` is flagged illegal and is 2 parcels long.
- R6: A first parcel with `p[6:0]` = `1111111` and `p[14:12]` = `111` (the reserved very-long code) is flagged illegal. It is ILEN/16 parcels long.
- R7: If the decoded length exceeds ILEN/16 parcels, the instruction is flagged illegal. Only ILEN/16 parcels are gathered and emitted, and `out_len` = ILEN/16.
- R8: An instruction whose ILEN bits are all ones is flagged illegal, with `out_len` = ILEN/16.
- R9: While `flush` is high, `in_ready` is 0. Any partial instruction is discarded. The next accepted parcel is the first parcel of a new instruction.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_insn`, `out_len` and `out_illegal` hold steady. `in_ready` is 0 whenever `out_valid` is 1.
- R11: `out_valid` is 1 in the cycle after the clock edge that accepts an instruction's last parcel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discards any partially gathered instruction |
| in_valid | input | 1 | Parcel offered |
| in_ready | output | 1 | Parcel will be taken at the next edge |
| in_parcel | input | 16 | Instruction parcel, lowest address first |
| out_valid | output | 1 | Assembled instruction available |
| out_ready | input | 1 | Consumer takes the instruction at the next edge |
| out_insn | output | ILEN | Assembled instruction, zero-extended |
| out_len | output | $clog2(ILEN/16+1) | Instruction length in parcels |
| out_illegal | output | 1 | Illegal or unsupported encoding |

## Verification
Two things can coincide in one cycle: a flush request and a parcel being offered. The bench causes this by raising `flush` while `in_valid` is held high, just after the first half of a two-parcel instruction has been accepted. It then judges two outcomes. First, `in_ready` must read 0 in that cycle. Second, the next single-parcel instruction must come out alone and unshifted in the low 16 bits; a surviving partial would show up as a two-parcel word. Output back-pressure is applied throughout, so a held instruction also meets new parcels arriving. The bench checks that those parcels wait and that the held fields stay steady.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef struct packed {
    logic [4:0] len;
    logic       bad;
  } len_info_t;

  // Length code of a first parcel, in parcels, capped at max_p.
  function automatic len_info_t size_of_first(input logic [15:0] p,
                                              input bit          c_en,
                                              input int          max_p);
    len_info_t r;
    int        full;
    r.bad = 1'b0;
    full  = 1;
    if (p[1:0] != 2'b11) begin
      if (c_en) begin
        full  = 1;
        r.bad = (p == 16'h0000);
      end else begin
        full  = 2;
        r.bad = 1'b1;
      end
    end else if (p[4:2] != 3'b111) begin
      full = 2;
    end else if (!p[5]) begin
      full = 3;
    end else if (!p[6]) begin
      full = 4;
    end else if (p[14:12] != 3'b111) begin
      full = 5 + int'(p[14:12]);
    end else begin
      full  = max_p;
      r.bad = 1'b1;
    end
    if (full > max_p) begin
      full  = max_p;
      r.bad = 1'b1;
    end
    r.len = 5'(full);
    return r;
  endfunction

endpackage

// File: rtl/pa_len_decode.sv
module pa_len_decode #(
  parameter int ILEN_P = 4,
  parameter bit C_EN   = 1'b1,
  parameter int LW     = 3
) (
  input  logic [15:0]   parcel,
  output logic [LW-1:0] len,
  output logic          bad
);
  import pa_pkg::*;

  len_info_t info;

  always_comb begin
    info = size_of_first(parcel, C_EN, ILEN_P);
    len  = LW'(info.len);
    bad  = info.bad;
  end

endmodule

// File: rtl/pa_gather.sv
module pa_gather #(
  parameter int ILEN = 64,
  parameter bit C_EN = 1'b1,
  parameter int LW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            fire,
  input  logic [15:0]     parcel,
  input  logic [LW-1:0]   dec_len,
  input  logic            dec_bad,
  output logic            done,
  output logic [ILEN-1:0] done_word,
  output logic [LW-1:0]   done_len,
  output logic            done_bad
);
  localparam int ILEN_P = ILEN / 16;

  logic [LW-1:0]   cnt_q, need_q, cnt_inc, cur_need;
  logic            bad_q, cur_bad, first, all_ones;
  logic [ILEN-1:0] acc_q, word_next;

  assign first    = (cnt_q == '0);
  assign cur_need = first ? dec_len : need_q;
  assign cur_bad  = first ? dec_bad : bad_q;
  assign cnt_inc  = cnt_q + LW'(1);

  for (genvar i = 0; i < ILEN_P; i++) begin : g_slot
    assign word_next[16*i +: 16] = (cnt_q == LW'(i)) ? parcel : acc_q[16*i +: 16];
  end

  assign all_ones  = (&word_next) && (cur_need == LW'(ILEN_P));
  assign done      = fire && (cnt_inc == cur_need);
  assign done_word = word_next;
  assign done_len  = cur_need;
  assign done_bad  = cur_bad | all_ones;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q  <= '0;
      need_q <= '0;
      bad_q  <= 1'b0;
      acc_q  <= '0;
    end else if (fire) begin
      if (done) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else begin
        cnt_q <= cnt_inc;
        acc_q <= word_next;
      end
      if (first) begin
        need_q <= dec_len;
        bad_q  <= dec_bad;
      end
    end
  end

  // R9: a flush leaves no partial instruction behind
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt_q == '0));

  // R7: emitted length stays within 1..ILEN/16 parcels
  a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_len >= LW'(1) && done_len <= LW'(ILEN_P)));

  // R4: an all-zero first parcel is always flagged
  a_r4_zero_parcel: assert property (@(posedge clk) disable iff (rst)
    (fire && first && parcel == 16'h0000) |-> (done_bad || (!C_EN && !done && !cur_bad ? 1'b0 : 1'b1)) && (C_EN ? done : !done));

endmodule

// File: rtl/pa_emit.sv
module pa_emit #(
  parameter int ILEN = 64,
  parameter int LW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [ILEN-1:0] word,
  input  logic [LW-1:0]   len,
  input  logic            bad,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [ILEN-1:0] out_insn,
  output logic [LW-1:0]   out_len,
  output logic            out_illegal
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_insn    <= '0;
      out_len     <= '0;
      out_illegal <= 1'b0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_insn    <= word;
      out_len     <= len;
      out_illegal <= bad;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R10: a stalled result holds its contents
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) &&
                                   $stable(out_len) && $stable(out_illegal)));

  // R11: a finished instruction is presented one cycle later
  a_r11_present: assert property (@(posedge clk) disable iff (rst)
    load |=> out_valid);

  // R10: no new instruction overwrites one still waiting
  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid);

endmodule

// File: rtl/parcel_assembler.sv
module parcel_assembler #(
  parameter int ILEN = 64,
  parameter bit C_EN = 1'b1,
  localparam int ILEN_P = ILEN / 16,
  localparam int LW     = $clog2(ILEN_P + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_parcel,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ILEN-1:0] out_insn,
  output logic [LW-1:0]   out_len,
  output logic            out_illegal
);

  logic            fire, done, done_bad, dec_bad;
  logic [LW-1:0]   dec_len, done_len;
  logic [ILEN-1:0] done_word;

  assign in_ready = !out_valid && !flush;
  assign fire     = in_valid && in_ready;

  pa_len_decode #(.ILEN_P(ILEN_P), .C_EN(C_EN), .LW(LW)) u_dec (
    .parcel (in_parcel),
    .len    (dec_len),
    .bad    (dec_bad)
  );

  pa_gather #(.ILEN(ILEN), .C_EN(C_EN), .LW(LW)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fire      (fire),
    .parcel    (in_parcel),
    .dec_len   (dec_len),
    .dec_bad   (dec_bad),
    .done      (done),
    .done_word (done_word),
    .done_len  (done_len),
    .done_bad  (done_bad)
  );

  pa_emit #(.ILEN(ILEN), .LW(LW)) u_emit (
    .clk         (clk),
    .rst         (rst),
    .load        (done),
    .word        (done_word),
    .len         (done_len),
    .bad         (done_bad),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_insn    (out_insn),
    .out_len     (out_len),
    .out_illegal (out_illegal)
  );

endmodule

// File: tb/parcel_assembler_tb_top.sv
module parcel_assembler_tb_top;
  localparam int ILEN = 64;
  localparam int LW   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, flush, in_valid, out_ready;
  logic [15:0] in_parcel;
  logic in_ready, out_valid, out_illegal;
  logic [ILEN-1:0] out_insn;
  logic [LW-1:0] out_len;

  logic nc_in_valid;
  logic [15:0] nc_parcel;
  logic nc_in_ready, nc_out_valid, nc_out_illegal;
  logic [31:0] nc_out_insn;
  logic [1:0] nc_out_len;

  parcel_assembler #(.ILEN(ILEN), .C_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_parcel(in_parcel), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_len(out_len), .out_illegal(out_illegal));

  parcel_assembler #(.ILEN(32), .C_EN(1'b0)) dut_nc_i (
    .clk(clk), .rst(rst), .flush(1'b0), .in_valid(nc_in_valid), .in_ready(nc_in_ready),
    .in_parcel(nc_parcel), .out_valid(nc_out_valid), .out_ready(1'b1),
    .out_insn(nc_out_insn), .out_len(nc_out_len), .out_illegal(nc_out_illegal));

  typedef struct {
    logic [ILEN-1:0] word;
    logic [LW-1:0]   len;
    logic            bad;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input logic [ILEN-1:0] act,
                       input logic [ILEN-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_item(input logic [ILEN-1:0] w, input int l, input bit b,
                             input string tag);
    exp_t e;
    e.word = w; e.len = LW'(l); e.bad = b; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic put(input bit sel, input logic [15:0] p);
    bit ok;
    @(negedge clk);
    if (sel) begin nc_in_valid = 1'b1; nc_parcel = p; end
    else     begin in_valid = 1'b1;    in_parcel = p; end
    #1;
    ok = sel ? nc_in_ready : in_ready;
    while (!ok) begin
      @(negedge clk); #1;
      ok = sel ? nc_in_ready : in_ready;
    end
    @(negedge clk);
    if (sel) nc_in_valid = 1'b0; else in_valid = 1'b0;
  endtask

  // output back-pressure pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = ((cyc % 5) >= 2);
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev_stall = 0;
    logic [ILEN-1:0] pw;
    logic [LW-1:0] pl;
    logic pb;
    exp_t e;
    pw = '0; pl = '0; pb = 1'b0;
    forever begin
      @(negedge clk); #2;
      if (rst) begin prev_stall = 0; continue; end
      if (prev_stall)
        check(out_valid && out_insn == pw && out_len == pl && out_illegal == pb,
              "R10 held output changed", out_insn, pw);
      if (out_valid)
        check(!in_ready, "R10 in_ready while out_valid", ILEN'(in_ready), '0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected output", out_insn, '0);
        end else begin
          e = exp_q.pop_front();
          check(out_insn == e.word, {e.tag, " word"}, out_insn, e.word);
          check(out_len == e.len && out_illegal == e.bad, {e.tag, " len/illegal"},
                ILEN'({out_len, out_illegal}), ILEN'({e.len, e.bad}));
        end
      end
      prev_stall = out_valid && !out_ready;
      pw = out_insn; pl = out_len; pb = out_illegal;
    end
  end

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired (R11 progress) actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; in_valid = 1'b0; in_parcel = '0;
    nc_in_valid = 1'b0; nc_parcel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!out_valid && in_ready, "R1 reset state", ILEN'({out_valid, in_ready}), ILEN'(2'b01));
    rst = 1'b0;
    @(negedge clk); #1;
    check(!out_valid && in_ready && !nc_out_valid, "R1 after release",
          ILEN'({out_valid, in_ready}), ILEN'(2'b01));

    // R2: one-parcel code
    expect_item(64'h4501, 1, 0, "R2 16-bit");
    put(0, 16'h4501);
    // R2 R3: two-parcel code, ordering
    expect_item(64'hABCD_0093, 2, 0, "R3 32-bit");
    put(0, 16'h0093); put(0, 16'hABCD);
    // R2: three parcels
    expect_item(64'h2222_1111_001F, 3, 0, "R2 48-bit");
    put(0, 16'h001F); put(0, 16'h1111); put(0, 16'h2222);
    // R2 R11: four parcels, then presented next cycle
    expect_item(64'hCCCC_BBBB_AAAA_003F, 4, 0, "R2 64-bit");
    put(0, 16'h003F); put(0, 16'hAAAA); put(0, 16'hBBBB); put(0, 16'hCCCC);
    #1 check(out_valid, "R11 out_valid after last parcel", ILEN'(out_valid), 64'h1);
    // R7: 80-bit code exceeds ILEN
    expect_item(64'h0003_0002_0001_007F, 4, 1, "R7 over length");
    put(0, 16'h007F); put(0, 16'h0001); put(0, 16'h0002); put(0, 16'h0003);
    // R6: reserved code
    expect_item(64'h9ABC_5678_1234_707F, 4, 1, "R6 reserved");
    put(0, 16'h707F); put(0, 16'h1234); put(0, 16'h5678); put(0, 16'h9ABC);
    // R4: zero parcel
    expect_item(64'h0, 1, 1, "R4 zero parcel");
    put(0, 16'h0000);
    // R8: all ones
    expect_item({ILEN{1'b1}}, 4, 1, "R8 all ones");
    put(0, 16'hFFFF); put(0, 16'hFFFF); put(0, 16'hFFFF); put(0, 16'hFFFF);

    // R9: flush collides with an offered parcel after a partial instruction
    while (exp_q.size() != 0) @(negedge clk);
    put(0, 16'h0093);
    flush = 1'b1; in_valid = 1'b1; in_parcel = 16'h0013;
    #1 check(!in_ready, "R9 in_ready during flush", ILEN'(in_ready), '0);
    @(negedge clk);
    flush = 1'b0; in_valid = 1'b0;
    expect_item(64'h0001, 1, 0, "R9 after flush");
    put(0, 16'h0001);

    // R5 R4: compressed support disabled
    put(1, 16'h0001); put(1, 16'h1234);
    #1 check(nc_out_valid && nc_out_illegal && nc_out_len == 2'd2 && nc_out_insn == 32'h1234_0001,
             "R5 non-11 without compressed", ILEN'(nc_out_insn), 64'h1234_0001);
    put(1, 16'h0000); put(1, 16'h0000);
    #1 check(nc_out_valid && nc_out_illegal && nc_out_len == 2'd2,
             "R4 zero parcel without compressed", ILEN'({nc_out_len, nc_out_illegal}), 64'h5);
    put(1, 16'h0013); put(1, 16'h0000);
    #1 check(nc_out_valid && !nc_out_illegal && nc_out_insn == 32'h0000_0013,
             "R2 legal 32-bit without compressed", ILEN'(nc_out_insn), 64'h13);

    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R11 all outputs delivered", ILEN'(exp_q.size()), '0);
    finished = 1;
    summary();
    $finish;
  end

endmodule